// File: doc/BRIEF.md
# Remote Defect Indication Insertion Controller

This block sits between a high-order path overhead monitor and the overhead generator. For every high-order path it picks the remote information that the generator will insert. Remote information is an REI error count and an RDI code, where a nonzero code is a plain or enhanced RDI. There are three candidates. The first is the local monitor's own report. The second is a ring report that arrives from inside the device. The third is a ring report that arrives from outside it. Every accepted local report is also sent out unchanged, so that a ring partner can use it.

Paths share the hardware in time-division order. Each sample carries a path index. Per-path configuration and stretch state live in small register arrays whose depth is set by a parameter. New configuration is written into a staging copy. The staging copy becomes active for all paths together at the next frame pulse. With stretching enabled for a path, any RDI insertion lasts at least a parameterised number of frames (20 by default).

Samples enter on a valid/ready stream and leave on a valid/ready stream through one register stage. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output holds its contents and no new sample is taken. The frame pulse and the configuration writes are plain pins and are never back-pressured.

Top module: `rdi_insert_ctrl`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, every path's active configuration selects the local source with stretching off, and every stretch counter is zero.
- R2: A path whose active source bit is 0 outputs the local candidate's REI and RDI code.
- R3: A path whose active source bit is 1 outputs the internal ring candidate when its ring-select bit is 0, and the external ring candidate when that bit is 1.
- R4: A configuration write changes only the staged setting of that path. The setting takes effect at the first `frame_tick` after the write. Samples taken before that tick still use the previous setting.
- R5: `out_ring_rei` and `out_ring_rdi` carry the accepted sample's local candidate, whatever source is selected.
- R6: With stretching off for a path, `out_rdi` equals the selected RDI code of that sample, with no extension.
- R7: With stretching on, a selected RDI code that changes from zero to nonzero on a path reloads that path's counter to STRETCH_FRAMES. Each `frame_tick` lowers every nonzero counter by one. While a path's counter is nonzero, a sample whose selected code is zero outputs the most recent nonzero code of that path. So after the rise, 19 ticks still stretch and the 20th tick ends the stretch.
- R8: `out_rei` is the selected REI value unchanged. It is never held or extended.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and every output field stays stable.
- R10: A sample whose path index is NPATH or larger is consumed but dropped. It produces no output and changes no per-path state. Configuration writes to such an index are ignored.
- R11: An accepted in-range sample appears on the output one cycle later, with `out_path` equal to its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | Frame boundary pulse: commits staged configuration, advances stretch counters |
| cfg_we | input | 1 | Staged configuration write strobe |
| cfg_path | input | PATH_W | Path written by cfg_we |
| cfg_src_ring | input | 1 | Source: 0 local, 1 ring |
| cfg_ring_ext | input | 1 | Ring candidate: 0 internal, 1 external |
| cfg_extend | input | 1 | Enable minimum-duration RDI stretching |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_path | input | PATH_W | Path index of the sample |
| loc_rei | input | REI_W | Local monitor REI count |
| loc_rdi | input | RDI_W | Local monitor RDI code (0 = no RDI) |
| rint_rei | input | REI_W | Internal ring REI count |
| rint_rdi | input | RDI_W | Internal ring RDI code |
| rext_rei | input | REI_W | External ring REI count |
| rext_rdi | input | RDI_W | External ring RDI code |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_path | output | PATH_W | Path index of the output sample |
| out_rei | output | REI_W | REI value to insert |
| out_rdi | output | RDI_W | RDI code to insert, after stretching |
| out_ring_rei | output | REI_W | Local REI exported toward the ring |
| out_ring_rdi | output | RDI_W | Local RDI code exported toward the ring |

## Verification
The bench builds the block with NPATH=6, so the 3-bit path index also reaches the unused indices 6 and 7. This exercises the drop rule and the ignored configuration writes. STRETCH_FRAMES keeps its default of 20, so the stretch boundary is checked at the full 19th and 20th frame. The 4-bit REI and 3-bit RDI widths let random traffic cover every code value. Random traffic over six paths mixes staged writes, frame pulses and samples, so configuration changes and running stretch counters interleave across paths.

// File: rtl/rdi_insert_pkg.sv
package rdi_insert_pkg;

  // Per-path selection; first field is the most significant bit.
  typedef struct packed {
    logic src_ring;   // 0: local monitor, 1: ring
    logic ring_ext;   // 0: internal ring, 1: external ring
    logic extend;     // minimum-duration RDI stretching
  } ri_cfg_t;

  localparam ri_cfg_t RI_CFG_RESET = '0;

endpackage

// File: rtl/ri_cfg_bank.sv
module ri_cfg_bank
  import rdi_insert_pkg::*;
#(
  parameter int NPATH  = 12,
  parameter int PATH_W = $clog2(NPATH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              wr_en,
  input  logic [PATH_W-1:0] wr_path,
  input  ri_cfg_t           wr_cfg,
  input  logic [PATH_W-1:0] rd_path,
  output ri_cfg_t           rd_cfg
);

  ri_cfg_t stg_q [NPATH];
  ri_cfg_t act_q [NPATH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPATH; p++) begin
        stg_q[p] <= RI_CFG_RESET;
        act_q[p] <= RI_CFG_RESET;
      end
    end else begin
      for (int p = 0; p < NPATH; p++) begin
        if (frame_tick) act_q[p] <= stg_q[p];
        if (wr_en && (int'(wr_path) == p)) stg_q[p] <= wr_cfg;
      end
    end
  end

  always_comb begin
    rd_cfg = RI_CFG_RESET;
    for (int p = 0; p < NPATH; p++) begin
      if (int'(rd_path) == p) rd_cfg = act_q[p];
    end
  end

endmodule

// File: rtl/ri_src_mux.sv
module ri_src_mux
  import rdi_insert_pkg::*;
#(
  parameter int REI_W = 4,
  parameter int RDI_W = 3
) (
  input  ri_cfg_t          cfg,
  input  logic [REI_W-1:0] loc_rei,
  input  logic [RDI_W-1:0] loc_rdi,
  input  logic [REI_W-1:0] rint_rei,
  input  logic [RDI_W-1:0] rint_rdi,
  input  logic [REI_W-1:0] rext_rei,
  input  logic [RDI_W-1:0] rext_rdi,
  output logic [REI_W-1:0] sel_rei,
  output logic [RDI_W-1:0] sel_rdi
);

  always_comb begin
    if (!cfg.src_ring) begin
      sel_rei = loc_rei;
      sel_rdi = loc_rdi;
    end else if (cfg.ring_ext) begin
      sel_rei = rext_rei;
      sel_rdi = rext_rdi;
    end else begin
      sel_rei = rint_rei;
      sel_rdi = rint_rdi;
    end
  end

endmodule

// File: rtl/ri_stretch_bank.sv
module ri_stretch_bank #(
  parameter int NPATH          = 12,
  parameter int PATH_W         = $clog2(NPATH),
  parameter int RDI_W          = 3,
  parameter int STRETCH_FRAMES = 20,
  parameter int CNT_W          = $clog2(STRETCH_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              upd,
  input  logic [PATH_W-1:0] upd_path,
  input  logic [RDI_W-1:0]  raw_code,
  output logic              hold_live,
  output logic [RDI_W-1:0]  hold_code
);

  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STRETCH_FRAMES);

  logic [CNT_W-1:0] cnt_q  [NPATH];
  logic [RDI_W-1:0] code_q [NPATH];
  logic             act_q  [NPATH];

  wire raw_on = (raw_code != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < NPATH; p++) begin
        cnt_q[p]  <= '0;
        code_q[p] <= '0;
        act_q[p]  <= 1'b0;
      end
    end else begin
      for (int p = 0; p < NPATH; p++) begin
        if (frame_tick && (cnt_q[p] != '0)) cnt_q[p] <= cnt_q[p] - 1'b1;
        if (upd && (int'(upd_path) == p)) begin
          if (raw_on) begin
            code_q[p] <= raw_code;
            if (!act_q[p]) cnt_q[p] <= RELOAD;
          end
          act_q[p] <= raw_on;
        end
      end
    end
  end

  always_comb begin
    hold_live = 1'b0;
    hold_code = '0;
    for (int p = 0; p < NPATH; p++) begin
      if (int'(upd_path) == p) begin
        hold_live = (cnt_q[p] != '0);
        hold_code = code_q[p];
      end
    end
  end

endmodule

// File: rtl/ri_out_reg.sv
module ri_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= load;
      if (load) out_data <= in_data;
    end
  end

endmodule

// File: rtl/rdi_insert_ctrl.sv
module rdi_insert_ctrl
  import rdi_insert_pkg::*;
#(
  parameter int NPATH          = 12,
  parameter int PATH_W         = $clog2(NPATH),
  parameter int REI_W          = 4,
  parameter int RDI_W          = 3,
  parameter int STRETCH_FRAMES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              cfg_we,
  input  logic [PATH_W-1:0] cfg_path,
  input  logic              cfg_src_ring,
  input  logic              cfg_ring_ext,
  input  logic              cfg_extend,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PATH_W-1:0] in_path,
  input  logic [REI_W-1:0]  loc_rei,
  input  logic [RDI_W-1:0]  loc_rdi,
  input  logic [REI_W-1:0]  rint_rei,
  input  logic [RDI_W-1:0]  rint_rdi,
  input  logic [REI_W-1:0]  rext_rei,
  input  logic [RDI_W-1:0]  rext_rdi,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PATH_W-1:0] out_path,
  output logic [REI_W-1:0]  out_rei,
  output logic [RDI_W-1:0]  out_rdi,
  output logic [REI_W-1:0]  out_ring_rei,
  output logic [RDI_W-1:0]  out_ring_rdi
);

  localparam int CNT_W = $clog2(STRETCH_FRAMES + 1);
  localparam int PAY_W = PATH_W + 2 * (REI_W + RDI_W);

  ri_cfg_t          wr_cfg, cur_cfg;
  logic [REI_W-1:0] sel_rei;
  logic [RDI_W-1:0] sel_rdi, hold_code, fin_rdi;
  logic             hold_live, in_range, take;
  logic [PAY_W-1:0] pay_in, pay_out;

  assign wr_cfg   = '{src_ring: cfg_src_ring, ring_ext: cfg_ring_ext, extend: cfg_extend};
  assign in_range = (int'(in_path) < NPATH);
  assign take     = in_valid && in_ready && in_range;

  ri_cfg_bank #(.NPATH(NPATH), .PATH_W(PATH_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .wr_en(cfg_we), .wr_path(cfg_path), .wr_cfg(wr_cfg),
    .rd_path(in_path), .rd_cfg(cur_cfg)
  );

  ri_src_mux #(.REI_W(REI_W), .RDI_W(RDI_W)) u_mux (
    .cfg(cur_cfg),
    .loc_rei(loc_rei), .loc_rdi(loc_rdi),
    .rint_rei(rint_rei), .rint_rdi(rint_rdi),
    .rext_rei(rext_rei), .rext_rdi(rext_rdi),
    .sel_rei(sel_rei), .sel_rdi(sel_rdi)
  );

  ri_stretch_bank #(
    .NPATH(NPATH), .PATH_W(PATH_W), .RDI_W(RDI_W),
    .STRETCH_FRAMES(STRETCH_FRAMES), .CNT_W(CNT_W)
  ) u_str (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .upd(take), .upd_path(in_path), .raw_code(sel_rdi),
    .hold_live(hold_live), .hold_code(hold_code)
  );

  // A live code wins; a cleared code is replaced by the held one while stretching.
  always_comb begin
    if (sel_rdi != '0)                  fin_rdi = sel_rdi;
    else if (cur_cfg.extend && hold_live) fin_rdi = hold_code;
    else                                fin_rdi = '0;
  end

  assign pay_in = {in_path, sel_rei, fin_rdi, loc_rei, loc_rdi};

  ri_out_reg #(.W(PAY_W)) u_out (
    .clk(clk), .rst_n(rst_n),
    .load(in_valid && in_range), .in_ready(in_ready), .in_data(pay_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(pay_out)
  );

  assign {out_path, out_rei, out_rdi, out_ring_rei, out_ring_rdi} = pay_out;

endmodule

// File: rtl/rdi_insert_chk.sv
module rdi_insert_chk #(
  parameter int NPATH  = 12,
  parameter int PATH_W = $clog2(NPATH),
  parameter int REI_W  = 4,
  parameter int RDI_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [PATH_W-1:0] in_path,
  input logic [REI_W-1:0]  loc_rei,
  input logic [RDI_W-1:0]  loc_rdi,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PATH_W-1:0] out_path,
  input logic [REI_W-1:0]  out_rei,
  input logic [RDI_W-1:0]  out_rdi,
  input logic [REI_W-1:0]  out_ring_rei,
  input logic [RDI_W-1:0]  out_ring_rdi
);

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_path) && $stable(out_rei)
                                   && $stable(out_rdi) && $stable(out_ring_rei)));

  // R10
  drop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (int'(in_path) >= NPATH)) |=> !out_valid);

  // R11
  one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (int'(in_path) < NPATH)) |=> (out_valid && out_path == $past(in_path)));

  // R5
  ring_export_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (int'(in_path) < NPATH)) |=>
      (out_ring_rei == $past(loc_rei) && out_ring_rdi == $past(loc_rdi)));

endmodule

bind rdi_insert_ctrl rdi_insert_chk #(
  .NPATH(NPATH), .PATH_W(PATH_W), .REI_W(REI_W), .RDI_W(RDI_W)
) u_rdi_insert_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_path(in_path), .loc_rei(loc_rei), .loc_rdi(loc_rdi),
  .out_valid(out_valid), .out_ready(out_ready), .out_path(out_path),
  .out_rei(out_rei), .out_rdi(out_rdi),
  .out_ring_rei(out_ring_rei), .out_ring_rdi(out_ring_rdi)
);

// File: tb/test_rdi_insert_ctrl.sv
module test_rdi_insert_ctrl;

  localparam int NP = 6;
  localparam int PW = 3;
  localparam int SF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_tick = 1'b0, cfg_we = 1'b0;
  logic [PW-1:0] cfg_path = '0;
  logic cfg_src_ring = 1'b0, cfg_ring_ext = 1'b0, cfg_extend = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [PW-1:0] in_path = '0;
  logic [3:0] loc_rei = '0, rint_rei = '0, rext_rei = '0;
  logic [2:0] loc_rdi = '0, rint_rdi = '0, rext_rdi = '0;
  logic out_valid, out_ready = 1'b1;
  logic [PW-1:0] out_path;
  logic [3:0] out_rei, out_ring_rei;
  logic [2:0] out_rdi, out_ring_rdi;

  int checks = 0;
  int errors = 0;

  // Reference state: cfg bits {src_ring, ring_ext, extend}
  logic [2:0] m_stg [NP];
  logic [2:0] m_act [NP];
  int         m_cnt [NP];
  logic       m_last [NP];
  logic [2:0] m_code [NP];

  always #5 clk = ~clk;

  rdi_insert_ctrl #(.NPATH(NP), .PATH_W(PW), .REI_W(4), .RDI_W(3), .STRETCH_FRAMES(SF)) i_rdi_insert_ctrl (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .cfg_we(cfg_we), .cfg_path(cfg_path), .cfg_src_ring(cfg_src_ring),
    .cfg_ring_ext(cfg_ring_ext), .cfg_extend(cfg_extend),
    .in_valid(in_valid), .in_ready(in_ready), .in_path(in_path),
    .loc_rei(loc_rei), .loc_rdi(loc_rdi), .rint_rei(rint_rei), .rint_rdi(rint_rdi),
    .rext_rei(rext_rei), .rext_rdi(rext_rdi),
    .out_valid(out_valid), .out_ready(out_ready), .out_path(out_path),
    .out_rei(out_rei), .out_rdi(out_rdi),
    .out_ring_rei(out_ring_rei), .out_ring_rdi(out_ring_rdi)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_stg[p] = '0; m_act[p] = '0; m_cnt[p] = 0; m_last[p] = 1'b0; m_code[p] = '0;
    end
  endtask

  task automatic do_cfg(input int p, input bit s, input bit e, input bit x);
    @(negedge clk);
    cfg_we = 1'b1; cfg_path = PW'(p);
    cfg_src_ring = s; cfg_ring_ext = e; cfg_extend = x;
    if (p < NP) m_stg[p] = {s, e, x};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_tick();
    @(negedge clk);
    frame_tick = 1'b1;
    for (int p = 0; p < NP; p++) begin
      m_act[p] = m_stg[p];
      if (m_cnt[p] > 0) m_cnt[p]--;
    end
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  // Expected output per requirements; updates reference state
  task automatic model_sample(input int p, input logic [3:0] lr, input logic [2:0] ld,
                              input logic [3:0] ir, input logic [2:0] id,
                              input logic [3:0] er, input logic [2:0] ed,
                              output logic [3:0] e_rei, output logic [2:0] e_rdi);
    logic [2:0] c;
    logic [2:0] sd;
    c = m_act[p];
    if (!c[2])     begin e_rei = lr; sd = ld; end
    else if (c[1]) begin e_rei = er; sd = ed; end
    else           begin e_rei = ir; sd = id; end
    if (sd != 0)                     e_rdi = sd;
    else if (c[0] && m_cnt[p] != 0)  e_rdi = m_code[p];
    else                             e_rdi = '0;
    if (sd != 0) begin
      m_code[p] = sd;
      if (!m_last[p]) m_cnt[p] = SF;
    end
    m_last[p] = (sd != 0);
  endtask

  task automatic drive_in(input int p, input logic [3:0] lr, input logic [2:0] ld,
                          input logic [3:0] ir, input logic [2:0] id,
                          input logic [3:0] er, input logic [2:0] ed);
    in_valid = 1'b1; in_path = PW'(p);
    loc_rei = lr; loc_rdi = ld; rint_rei = ir; rint_rdi = id; rext_rei = er; rext_rdi = ed;
  endtask

  task automatic send(input int p, input logic [3:0] lr, input logic [2:0] ld,
                      input logic [3:0] ir, input logic [2:0] id,
                      input logic [3:0] er, input logic [2:0] ed, input string tag);
    logic [3:0] e_rei;
    logic [2:0] e_rdi;
    @(negedge clk);
    drive_in(p, lr, ld, ir, id, er, ed);
    if (p < NP) model_sample(p, lr, ld, ir, id, er, ed, e_rei, e_rdi);
    @(negedge clk);
    in_valid = 1'b0;
    if (p >= NP) begin
      chk(out_valid == 1'b0, "R10 out-of-range sample dropped", int'(out_valid), 0);
    end else begin
      chk(out_valid == 1'b1 && out_path == PW'(p), "R11 output path after one cycle", int'(out_path), p);
      chk(out_rei == e_rei, {tag, " R8 rei"}, int'(out_rei), int'(e_rei));
      chk(out_rdi == e_rdi, {tag, " rdi"}, int'(out_rdi), int'(e_rdi));
      chk(out_ring_rei == lr && out_ring_rdi == ld, "R5 ring export", int'({out_ring_rei, out_ring_rdi}), int'({lr, ld}));
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R11 actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [3:0] a_rei;
    logic [2:0] a_rdi;
    logic [3:0] b_rei;
    logic [2:0] b_rdi;
    void'($urandom(32'd4711));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    send(0, 4'd3, 3'd2, 4'd9, 3'd5, 4'd12, 3'd6, "R1 R2 default local");

    // R4 staged write not yet active, R3 ring selections
    do_cfg(1, 1'b1, 1'b0, 1'b0);
    send(1, 4'd1, 3'd1, 4'd7, 3'd4, 4'd11, 3'd3, "R4 before tick");
    do_tick();
    send(1, 4'd1, 3'd1, 4'd7, 3'd4, 4'd11, 3'd3, "R3 ring internal");
    do_cfg(1, 1'b1, 1'b1, 1'b0);
    do_tick();
    send(1, 4'd2, 3'd0, 4'd6, 3'd0, 4'd13, 3'd7, "R3 ring external");

    // R6 no stretching
    send(4, 4'd0, 3'd3, 4'd0, 3'd0, 4'd0, 3'd0, "R6 raw on");
    do_tick();
    send(4, 4'd0, 3'd0, 4'd0, 3'd0, 4'd0, 3'd0, "R6 raw off");

    // R7 stretch boundary
    do_cfg(2, 1'b0, 1'b0, 1'b1);
    do_tick();
    send(2, 4'd5, 3'd5, 4'd0, 3'd0, 4'd0, 3'd0, "R7 rise");
    for (int k = 1; k < SF; k++) begin
      do_tick();
      send(2, 4'd4, 3'd0, 4'd0, 3'd0, 4'd0, 3'd0, "R7 held");
    end
    do_tick();
    send(2, 4'd4, 3'd0, 4'd0, 3'd0, 4'd0, 3'd0, "R7 expired");

    // R10 out-of-range path and write
    do_cfg(7, 1'b1, 1'b1, 1'b1);
    send(7, 4'd8, 3'd2, 4'd8, 3'd2, 4'd8, 3'd2, "R10");
    do_tick();
    send(0, 4'd6, 3'd1, 4'd2, 3'd2, 4'd3, 3'd3, "R10 path0 unchanged");

    // R9 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    drive_in(3, 4'd10, 3'd2, 4'd0, 3'd0, 4'd0, 3'd0);
    model_sample(3, 4'd10, 3'd2, 4'd0, 3'd0, 4'd0, 3'd0, a_rei, a_rdi);
    @(negedge clk);
    drive_in(5, 4'd14, 3'd6, 4'd0, 3'd0, 4'd0, 3'd0);
    for (int k = 0; k < 3; k++) begin
      chk(in_ready == 1'b0, "R9 in_ready low on stall", int'(in_ready), 0);
      chk(out_valid && out_path == 3'd3 && out_rei == a_rei && out_rdi == a_rdi,
          "R9 output held", int'(out_rei), int'(a_rei));
      @(negedge clk);
    end
    model_sample(5, 4'd14, 3'd6, 4'd0, 3'd0, 4'd0, 3'd0, b_rei, b_rdi);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_path == 3'd5 && out_rei == b_rei && out_rdi == b_rdi,
        "R9 stalled sample delivered", int'(out_rei), int'(b_rei));

    // Random traffic: R2 R3 R4 R6 R7 R8 R10
    for (int n = 0; n < 600; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op == 0) begin
        do_cfg(int'($urandom_range(0, 7)), 1'($urandom), 1'($urandom), 1'($urandom));
      end else if (op <= 2) begin
        do_tick();
      end else begin
        send(int'($urandom_range(0, 7)),
             4'($urandom), ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom),
             4'($urandom), ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom),
             4'($urandom), ($urandom_range(0, 1) == 0) ? 3'd0 : 3'($urandom),
             "random R2 R3 R6 R7");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule